// File: doc/BRIEF.md
# Conditional ALU with Flag Update

This block is the execute stage of a 32-bit RISC core for data-processing instructions. Each cycle it receives an operation code, a 4-bit condition code, a set-flags bit, a first operand, an already-shifted second operand, the carry out of the shifter and the current N, Z, C and V flags. It returns the registered result, a destination write strobe and the flag value the core should hold next.

Before anything is committed, the condition is evaluated against the incoming flags. When the condition fails, the instruction becomes a bubble: the destination is not written and the flags pass through unchanged. Compare and test operations exist only for their flags. They always update the flags when their condition holds and they never write the destination. Every other operation changes the flags only when the set-flags bit is high.

All outputs are registered, so there is one cycle of latency. The flag vector is packed as bit 3 = N, bit 2 = Z, bit 1 = C, bit 0 = V.

Top module: `cond_alu`

## Requirements
- R1: The condition code selects the execute test on the incoming flags: 0 Z, 1 !Z, 2 C, 3 !C, 4 N, 5 !N, 6 V, 7 !V, 8 C&!Z, 9 !C|Z, 10 N==V, 11 N!=V, 12 !Z&(N==V), 13 Z|(N!=V), 14 always. When the test is false, `regWrite` is 0 and `flagsOut` equals `flagsIn`.
- R2: Outputs are registered with a latency of one clock. While `rst_n` is low, `resultOut`, `regWrite` and `flagsOut` are all zero.
- R3: Arithmetic operation codes: 4 ADD gives A+B, 2 SUB gives A-B, 3 RSB gives B-A, 7 CMP computes A-B, and 8 CMN computes A+B. All results are taken modulo 2^32.
- R4: Logical operation codes: 0 AND, 1 EOR, 9 ORR, 11 BIC (A & ~B), 10 MOV (B), 12 MVN (~B), 5 TST (computes A&B) and 6 TEQ (computes A^B).
- R5: When the flags update, N equals bit 31 of the computed value and Z is 1 exactly when the computed value is zero.
- R6: When an arithmetic operation updates the flags, C is the carry out of the addition. For a subtraction, C is 1 when no borrow occurs and 0 when one does. V is 1 on two's-complement overflow.
- R7: When a logical operation updates the flags, C takes `shiftCarry` and V keeps its incoming value.
- R8: For a passing condition, the flags update when `setFlagsBit` is 1 or when the operation is CMP, CMN, TST or TEQ. CMP, CMN, TST and TEQ never assert `regWrite`. Every other defined operation asserts it.
- R9: Operation codes 13, 14 and 15 are undefined. They never write the destination and never change the flags.
- R10: Condition code 15 never executes. `regWrite` is 0 and the flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| opCode | input | 4 | Operation code |
| condCode | input | 4 | Condition code |
| setFlagsBit | input | 1 | Request to update flags |
| operandA | input | 32 | First operand |
| operandB | input | 32 | Shifted second operand |
| shiftCarry | input | 1 | Carry out of the shifter |
| flagsIn | input | 4 | Current flags {N,Z,C,V} |
| resultOut | output | 32 | Registered result |
| regWrite | output | 1 | Registered destination write strobe |
| flagsOut | output | 4 | Registered next flags {N,Z,C,V} |

## Verification
A wrong condition decode appears one cycle later as a write strobe, or a flag change, on an instruction that should have been a bubble. To expose it, every condition code is swept against all sixteen flag values. A faulty adder carry or overflow term shows up only at the carry, borrow and sign-overflow corners, so those corners are driven directly. They are then mixed with seeded random operations that are biased toward boundary operands. Because the block holds no state beyond its output registers, any fault becomes visible at the ports on the very next cycle.

// File: rtl/cond_alu_pkg.sv
package cond_alu_pkg;

  typedef enum logic [3:0] {
    OP_AND = 4'd0,
    OP_EOR = 4'd1,
    OP_SUB = 4'd2,
    OP_RSB = 4'd3,
    OP_ADD = 4'd4,
    OP_TST = 4'd5,
    OP_TEQ = 4'd6,
    OP_CMP = 4'd7,
    OP_CMN = 4'd8,
    OP_ORR = 4'd9,
    OP_MOV = 4'd10,
    OP_BIC = 4'd11,
    OP_MVN = 4'd12,
    OP_RS13 = 4'd13,
    OP_RS14 = 4'd14,
    OP_RS15 = 4'd15
  } aluOp_e;

  typedef enum logic [2:0] {
    LG_AND = 3'd0,
    LG_EOR = 3'd1,
    LG_ORR = 3'd2,
    LG_BIC = 3'd3,
    LG_PASSB = 3'd4,
    LG_NOTB = 3'd5
  } logicSel_e;

  localparam int FLAG_N = 3;
  localparam int FLAG_Z = 2;
  localparam int FLAG_C = 1;
  localparam int FLAG_V = 0;

  typedef struct packed {
    logic      condPass;
    logic      writeReg;
    logic      setFlags;
    logic      useArith;
    logic      swapOps;
    logic      invSecond;
    logic      carryIn;
    logicSel_e logicSel;
  } ctrlStrobe_t;

endpackage

// File: rtl/cond_alu_ctrl.sv
module cond_alu_ctrl
  import cond_alu_pkg::*;
(
  input  logic [3:0]  opCode,
  input  logic [3:0]  condCode,
  input  logic        setFlagsBit,
  input  logic [3:0]  flagsIn,
  output ctrlStrobe_t strobes
);

  logic nF, zF, cF, vF;
  logic condOk;
  logic isDefined, isCompare;
  aluOp_e op;

  assign nF = flagsIn[FLAG_N];
  assign zF = flagsIn[FLAG_Z];
  assign cF = flagsIn[FLAG_C];
  assign vF = flagsIn[FLAG_V];
  assign op = aluOp_e'(opCode);

  always_comb begin
    unique case (condCode)
      4'd0:    condOk = zF;
      4'd1:    condOk = !zF;
      4'd2:    condOk = cF;
      4'd3:    condOk = !cF;
      4'd4:    condOk = nF;
      4'd5:    condOk = !nF;
      4'd6:    condOk = vF;
      4'd7:    condOk = !vF;
      4'd8:    condOk = cF && !zF;
      4'd9:    condOk = !cF || zF;
      4'd10:   condOk = (nF == vF);
      4'd11:   condOk = (nF != vF);
      4'd12:   condOk = !zF && (nF == vF);
      4'd13:   condOk = zF || (nF != vF);
      4'd14:   condOk = 1'b1;
      default: condOk = 1'b0;
    endcase
  end

  always_comb begin
    isDefined = 1'b1;
    isCompare = 1'b0;
    strobes.useArith  = 1'b0;
    strobes.swapOps   = 1'b0;
    strobes.invSecond = 1'b0;
    strobes.carryIn   = 1'b0;
    strobes.logicSel  = LG_AND;
    unique case (op)
      OP_AND: strobes.logicSel = LG_AND;
      OP_EOR: strobes.logicSel = LG_EOR;
      OP_ORR: strobes.logicSel = LG_ORR;
      OP_BIC: strobes.logicSel = LG_BIC;
      OP_MOV: strobes.logicSel = LG_PASSB;
      OP_MVN: strobes.logicSel = LG_NOTB;
      OP_TST: begin strobes.logicSel = LG_AND; isCompare = 1'b1; end
      OP_TEQ: begin strobes.logicSel = LG_EOR; isCompare = 1'b1; end
      OP_ADD: strobes.useArith = 1'b1;
      OP_CMN: begin strobes.useArith = 1'b1; isCompare = 1'b1; end
      OP_SUB, OP_CMP: begin
        strobes.useArith  = 1'b1;
        strobes.invSecond = 1'b1;
        strobes.carryIn   = 1'b1;
        isCompare = (op == OP_CMP);
      end
      OP_RSB: begin
        strobes.useArith  = 1'b1;
        strobes.swapOps   = 1'b1;
        strobes.invSecond = 1'b1;
        strobes.carryIn   = 1'b1;
      end
      default: isDefined = 1'b0;
    endcase
    strobes.condPass = condOk;
    strobes.writeReg = condOk && isDefined && !isCompare;
    strobes.setFlags = condOk && isDefined && (setFlagsBit || isCompare);
  end

endmodule

// File: rtl/cond_alu_dp.sv
module cond_alu_dp
  import cond_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  ctrlStrobe_t        strobes,
  input  logic [DATA_W-1:0]  operandA,
  input  logic [DATA_W-1:0]  operandB,
  input  logic               shiftCarry,
  input  logic [3:0]         flagsIn,
  output logic [DATA_W-1:0]  result,
  output logic [3:0]         dpFlags
);

  localparam int MSB = DATA_W - 1;

  logic [DATA_W-1:0] addX, addY, logicVal;
  logic [DATA_W:0]   sumWide;
  logic              addCarry, addOvf;

  assign addX = strobes.swapOps ? operandB : operandA;
  assign addY = (strobes.swapOps ? operandA : operandB) ^ {DATA_W{strobes.invSecond}};
  assign sumWide = {1'b0, addX} + {1'b0, addY} + {{DATA_W{1'b0}}, strobes.carryIn};
  assign addCarry = sumWide[DATA_W];
  assign addOvf = (addX[MSB] == addY[MSB]) && (sumWide[MSB] != addX[MSB]);

  always_comb begin
    unique case (strobes.logicSel)
      LG_AND:   logicVal = operandA & operandB;
      LG_EOR:   logicVal = operandA ^ operandB;
      LG_ORR:   logicVal = operandA | operandB;
      LG_BIC:   logicVal = operandA & ~operandB;
      LG_PASSB: logicVal = operandB;
      LG_NOTB:  logicVal = ~operandB;
      default:  logicVal = '0;
    endcase
  end

  assign result = strobes.useArith ? sumWide[MSB:0] : logicVal;

  always_comb begin
    dpFlags[FLAG_N] = result[MSB];
    dpFlags[FLAG_Z] = (result == '0);
    dpFlags[FLAG_C] = strobes.useArith ? addCarry : shiftCarry;
    dpFlags[FLAG_V] = strobes.useArith ? addOvf : flagsIn[FLAG_V];
  end

endmodule

// File: rtl/cond_alu.sv
module cond_alu
  import cond_alu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        opCode,
  input  logic [3:0]        condCode,
  input  logic              setFlagsBit,
  input  logic [DATA_W-1:0] operandA,
  input  logic [DATA_W-1:0] operandB,
  input  logic              shiftCarry,
  input  logic [3:0]        flagsIn,
  output logic [DATA_W-1:0] resultOut,
  output logic              regWrite,
  output logic [3:0]        flagsOut
);

  ctrlStrobe_t       strobes;
  logic [DATA_W-1:0] dpResult;
  logic [3:0]        dpFlags;

  cond_alu_ctrl u_ctrl (
    .opCode      (opCode),
    .condCode    (condCode),
    .setFlagsBit (setFlagsBit),
    .flagsIn     (flagsIn),
    .strobes     (strobes)
  );

  cond_alu_dp #(.DATA_W(DATA_W)) u_dp (
    .strobes    (strobes),
    .operandA   (operandA),
    .operandB   (operandB),
    .shiftCarry (shiftCarry),
    .flagsIn    (flagsIn),
    .result     (dpResult),
    .dpFlags    (dpFlags)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      resultOut <= '0;
      regWrite  <= 1'b0;
      flagsOut  <= 4'h0;
    end else begin
      resultOut <= dpResult;
      regWrite  <= strobes.writeReg;
      flagsOut  <= strobes.setFlags ? dpFlags : flagsIn;
    end
  end

  // R1: failed condition leaves no trace
  p_cond_fail_bubble_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.condPass |=> (!regWrite && flagsOut == $past(flagsIn)));

  // R10: condition code 15 never executes
  p_cond_never_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (condCode == 4'd15) |=> (!regWrite && flagsOut == $past(flagsIn)));

  // R8: compare and test operations never write
  p_cmp_no_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode inside {4'd5, 4'd6, 4'd7, 4'd8}) |=> !regWrite);

  // R8: without S, non-compare ops keep flags
  p_no_s_keeps_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!setFlagsBit && !(opCode inside {4'd5, 4'd6, 4'd7, 4'd8})) |=> flagsOut == $past(flagsIn));

  // R9: undefined operations have no effect
  p_undef_op_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (opCode >= 4'd13) |=> (!regWrite && flagsOut == $past(flagsIn)));

  // R5: N and Z follow the registered result when flags update
  p_nz_match_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.setFlags |=> (flagsOut[FLAG_N] == resultOut[DATA_W-1] &&
                          flagsOut[FLAG_Z] == (resultOut == '0)));

  // R7: logical ops keep V
  p_logic_keeps_v_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobes.useArith) |=> flagsOut[FLAG_V] == $past(flagsIn[FLAG_V]));

endmodule

// File: tb/cond_alu_bench.sv
module cond_alu_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  opCode = '0, condCode = '0, flagsIn = '0;
  logic        setFlagsBit = 1'b0, shiftCarry = 1'b0;
  logic [31:0] operandA = '0, operandB = '0;
  logic [31:0] resultOut;
  logic        regWrite;
  logic [3:0]  flagsOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  cond_alu u_cond_alu (
    .clk(clk), .rst_n(rst_n), .opCode(opCode), .condCode(condCode),
    .setFlagsBit(setFlagsBit), .operandA(operandA), .operandB(operandB),
    .shiftCarry(shiftCarry), .flagsIn(flagsIn), .resultOut(resultOut),
    .regWrite(regWrite), .flagsOut(flagsOut)
  );

  function automatic bit condTrue(input logic [3:0] c, input logic [3:0] f);
    bit n = f[3], z = f[2], cy = f[1], v = f[0];
    case (c)
      0: return z;            1: return !z;
      2: return cy;           3: return !cy;
      4: return n;            5: return !n;
      6: return v;            7: return !v;
      8: return cy && !z;     9: return !cy || z;
      10: return n == v;      11: return n != v;
      12: return !z && n == v; 13: return z || n != v;
      14: return 1;
      default: return 0;
    endcase
  endfunction

  // returns {we, flags[3:0], result[31:0]}
  function automatic logic [36:0] refModel(input logic [3:0] op, input logic [3:0] c,
      input bit s, input logic [31:0] a, input logic [31:0] b, input bit sc,
      input logic [3:0] f);
    logic [31:0] r;
    logic signed [33:0] wide;
    bit arith = 0, cmp = 0, defd = 1, cy = sc, v = f[0];
    case (op)
      0: r = a & b;  1: r = a ^ b;  9: r = a | b;  11: r = a & ~b;
      10: r = b;     12: r = ~b;
      5: begin r = a & b; cmp = 1; end
      6: begin r = a ^ b; cmp = 1; end
      4, 8: begin
        arith = 1; cmp = (op == 8); r = a + b;
        cy = ({1'b0, a} + {1'b0, b}) > 33'hFFFFFFFF;
        wide = $signed({{2{a[31]}}, a}) + $signed({{2{b[31]}}, b});
        v = (wide > 34'sd2147483647) || (wide < -34'sd2147483648);
      end
      2, 7: begin
        arith = 1; cmp = (op == 7); r = a - b; cy = (a >= b);
        wide = $signed({{2{a[31]}}, a}) - $signed({{2{b[31]}}, b});
        v = (wide > 34'sd2147483647) || (wide < -34'sd2147483648);
      end
      3: begin
        arith = 1; r = b - a; cy = (b >= a);
        wide = $signed({{2{b[31]}}, b}) - $signed({{2{a[31]}}, a});
        v = (wide > 34'sd2147483647) || (wide < -34'sd2147483648);
      end
      default: begin defd = 0; r = '0; end
    endcase
    if (!condTrue(c, f) || !defd) return {1'b0, f, 32'h0};
    if (s || cmp) return {!cmp, r[31], r == 0, cy, v, r};
    return {!cmp, f, r};
  endfunction

  task automatic check(input string tag, input logic [35:0] got, input logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic apply(input string tag, input logic [3:0] op, input logic [3:0] c,
      input bit s, input logic [31:0] a, input logic [31:0] b, input bit sc,
      input logic [3:0] f);
    logic [36:0] e;
    @(negedge clk);
    opCode = op; condCode = c; setFlagsBit = s; operandA = a;
    operandB = b; shiftCarry = sc; flagsIn = f;
    e = refModel(op, c, s, a, b, sc, f);
    @(negedge clk);
    check({tag, " write"}, {35'h0, regWrite}, {35'h0, e[36]});
    check({tag, " flags"}, {32'h0, flagsOut}, {32'h0, e[35:32]});
    if (e[36]) check({tag, " result"}, {4'h0, resultOut}, {4'h0, e[31:0]});
  endtask

  function automatic logic [31:0] pickVal();
    case ($urandom % 6)
      0: return 32'h0;
      1: return 32'hFFFFFFFF;
      2: return 32'h7FFFFFFF;
      3: return 32'h80000000;
      4: return 32'h1;
      default: return $urandom;
    endcase
  endfunction

  initial begin
    #3_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R2: reset state
    check("R2 reset", {1'b0, regWrite, flagsOut, resultOut[29:0]}, 36'h0);
    check("R2 reset msb", {34'h0, resultOut[31:30]}, 36'h0);
    rst_n = 1'b1;

    // R1 / R10: every condition against every flag value (MOV with S)
    for (int c = 0; c < 16; c++)
      for (int f = 0; f < 16; f++)
        apply((c == 15) ? "R10 cond" : "R1 cond", 4'd10, 4'(c), 1'b1,
              32'h0, 32'h0, 1'b1, 4'(f));

    // R3 / R6: arithmetic corners
    apply("R6 add signed ovf", 4'd4, 4'd14, 1, 32'h7FFFFFFF, 32'h1, 0, 4'h0);
    apply("R6 add carry zero", 4'd4, 4'd14, 1, 32'hFFFFFFFF, 32'h1, 0, 4'h0);
    apply("R6 add both", 4'd4, 4'd14, 1, 32'h80000000, 32'h80000000, 0, 4'h0);
    apply("R6 sub borrow", 4'd2, 4'd14, 1, 32'h0, 32'h1, 0, 4'hF);
    apply("R6 sub equal", 4'd2, 4'd14, 1, 32'h5, 32'h5, 0, 4'h0);
    apply("R6 sub ovf", 4'd2, 4'd14, 1, 32'h80000000, 32'h1, 0, 4'h0);
    apply("R3 rsb", 4'd3, 4'd14, 1, 32'h1, 32'h0, 0, 4'h0);
    apply("R3 rsb ovf", 4'd3, 4'd14, 1, 32'h1, 32'h80000000, 0, 4'h0);
    apply("R8 cmp ovf", 4'd7, 4'd14, 0, 32'h7FFFFFFF, 32'hFFFFFFFF, 0, 4'h0);
    apply("R8 cmn carry", 4'd8, 4'd14, 0, 32'hFFFFFFFF, 32'h1, 0, 4'h0);
    // R4 / R7: logical ops
    apply("R7 tst carry", 4'd5, 4'd14, 0, 32'hF0, 32'h0F, 1, 4'h1);
    apply("R4 teq", 4'd6, 4'd14, 0, 32'h80000000, 32'h0, 0, 4'h0);
    apply("R4 mvn", 4'd12, 4'd14, 1, 32'h1234, 32'h0000FFFF, 1, 4'h0);
    apply("R4 bic", 4'd11, 4'd14, 0, 32'hFF, 32'h0F, 0, 4'h5);
    apply("R5 orr zero", 4'd9, 4'd14, 1, 32'h0, 32'h0, 0, 4'h0);
    // R9: undefined codes
    apply("R9 undef", 4'd13, 4'd14, 1, 32'h5, 32'h5, 1, 4'hA);
    apply("R9 undef", 4'd15, 4'd14, 1, 32'h5, 32'h5, 1, 4'h5);
    // R8: no S on ADD keeps flags
    apply("R8 add no s", 4'd4, 4'd14, 0, 32'hFFFFFFFF, 32'h1, 0, 4'h9);

    for (int i = 0; i < 3000; i++)
      apply("R3 R4 R5 random", 4'($urandom % 16), 4'(($urandom % 3 == 0) ? 14 : $urandom % 16),
            1'($urandom), pickVal(), pickVal(), 1'($urandom), 4'($urandom));

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule